// File: doc/BRIEF.md
# SEC-DED Codec with Address Binding

This block protects a 256-bit memory word with 10 check bits. On the write side a combinational encoder builds the check field from the data word and from the address the word is written to. The data and check field then go to storage together. On the read side a registered decoder recomputes the check bits from the returned data and the address of the read. It corrects any single flipped bit, flags double flips, and flags reads whose address does not match the address that was used on the write. Results arrive one cycle after the read is presented.

The check field has nine position-coded parity bits and one overall parity bit. The address is mixed into the nine position bits only. A fault on the address lines therefore looks like an even-weight error, and it is never mistaken for a single flip that could be corrected. A write-side injection path can flip one or two chosen bits of the outgoing data or check field, so the detection logic can be tested on demand.

Top module: `secded_addr_codec`

## Requirements
- R1: Without injection, `wr_mem_data` equals `wr_data`. Bits [8:0] of `wr_mem_chk` equal the XOR of a column over every set data bit and every set address bit. Data bit i has as its column its position p(i): the positions 1,2,3,... are taken in ascending order, powers of two are skipped, and data bit i gets the i-th of the remaining positions (0-based). Address bit j has the column j+1. Bit 9 makes the XOR of all 256 data bits and all 10 check bits equal 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `rd_valid` is high, and it is low otherwise.
- R3: A read of an unmodified word at its write address returns the data unchanged, with `out_ce` and `out_ue` both low.
- R4: A read with exactly one flipped data bit returns the original data, with `out_ce` high and `out_ue` low.
- R5: A read with exactly one flipped check bit (any of the 10) returns the data unchanged, with `out_ce` high and `out_ue` low.
- R6: A read with two flipped bits returns `out_ue` high and `out_ce` low. This holds whether both bits are in the data, both are in the check field, or one is in each.
- R7: A read whose address differs from the write address in one or two bits returns `out_ue` high and `out_ce` low.
- R8: While `out_valid` is high, `out_err_addr` equals the read address of that result if `out_ce` or `out_ue` is high, and equals 0 otherwise.
- R9: With `inj_en` high and `inj_double` low, exactly one bit is flipped: bit `inj_bit_a` of the data field when `inj_in_check` is 0, or of the check field when it is 1. A check-field index of 10 or more flips nothing.
- R10: With `inj_en` and `inj_double` high, the bits `inj_bit_a` and `inj_bit_b` of the selected field are both flipped.
- R11: While reset is held, and after its release until the first read, `out_valid`, `out_ce` and `out_ue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_data | input | 256 | Data word to be written |
| wr_addr | input | 32 | Address of the write |
| inj_en | input | 1 | Enable fault injection on the write path |
| inj_double | input | 1 | 1: flip two bits, 0: flip one bit |
| inj_in_check | input | 1 | 1: flip in the check field, 0: flip in the data field |
| inj_bit_a | input | 8 | First bit index to flip |
| inj_bit_b | input | 8 | Second bit index to flip (double mode) |
| wr_mem_data | output | 256 | Data word sent to storage |
| wr_mem_chk | output | 10 | Check field sent to storage |
| rd_valid | input | 1 | Read word present this cycle |
| rd_data | input | 256 | Data word returned from storage |
| rd_chk | input | 10 | Check field returned from storage |
| rd_addr | input | 32 | Address of the read |
| out_valid | output | 1 | Decoded result valid |
| out_data | output | 256 | Corrected data |
| out_ce | output | 1 | Correctable error was found |
| out_ue | output | 1 | Uncorrectable error or address mismatch was found |
| out_err_addr | output | 32 | Address of the failing read, 0 when clean |

## Verification
The encoder outputs are combinational. The bench sets the write inputs on a falling edge and reads `wr_mem_data` and `wr_mem_chk` one nanosecond later, in the same cycle. A read is presented on a falling edge with `rd_valid` high for one cycle. The decoded data, flags and error address are sampled on the next falling edge, after the single register stage has loaded. `out_valid` is sampled once more a cycle later to confirm it has dropped. The reset checks wait for the two-flop internal reset release before sampling.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_CORR   = 2'd1,
    CLS_UNCORR = 2'd2
  } err_cls_e;

  // number of position-coded check bits for a data width
  function automatic int ham_bits(input int dw);
    int k;
    k = 1;
    while ((1 << k) < dw + k + 1) k++;
    return k;
  endfunction

  // codeword position of data bit idx (powers of two hold check bits)
  function automatic int data_pos(input int idx);
    int p;
    int cnt;
    p   = 0;
    cnt = -1;
    while (cnt < idx) begin
      p++;
      if ((p & (p - 1)) != 0) cnt++;
    end
    return p;
  endfunction

endpackage

// File: rtl/secded_hamming.sv
module secded_hamming #(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 32,
  parameter int HAM_W  = 9
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  output logic [HAM_W-1:0]  ham
);
  import secded_pkg::*;

  logic [HAM_W-1:0] dcol [DATA_W];
  logic [HAM_W-1:0] acol [ADDR_W];

  // each data bit contributes its codeword position
  for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
    localparam int POS = data_pos(i);
    assign dcol[i] = data[i] ? HAM_W'(POS) : '0;
  end

  // each address bit contributes a distinct nonzero column
  for (genvar j = 0; j < ADDR_W; j++) begin : g_acol
    assign acol[j] = addr[j] ? HAM_W'(j + 1) : '0;
  end

  always_comb begin
    ham = '0;
    for (int i = 0; i < DATA_W; i++) ham = ham ^ dcol[i];
    for (int j = 0; j < ADDR_W; j++) ham = ham ^ acol[j];
  end

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder #(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 32,
  parameter int HAM_W  = 9,
  parameter int CHK_W  = 10,
  parameter int SEL_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              inj_en,
  input  logic              inj_double,
  input  logic              inj_in_check,
  input  logic [SEL_W-1:0]  inj_bit_a,
  input  logic [SEL_W-1:0]  inj_bit_b,
  output logic [DATA_W-1:0] mem_data,
  output logic [CHK_W-1:0]  mem_chk
);

  logic [HAM_W-1:0]  ham;
  logic              overall;
  logic [CHK_W-1:0]  chk_clean;
  logic [DATA_W-1:0] dmask;
  logic [CHK_W-1:0]  cmask;

  secded_hamming #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HAM_W  (HAM_W)
  ) u_gen (
    .data (data),
    .addr (addr),
    .ham  (ham)
  );

  assign overall   = (^data) ^ (^ham);
  assign chk_clean = {overall, ham};

  // injection masks: one or two selected bits in the chosen field
  for (genvar i = 0; i < DATA_W; i++) begin : g_dmask
    assign dmask[i] = inj_en & ~inj_in_check &
                      ((inj_bit_a == SEL_W'(i)) | (inj_double & (inj_bit_b == SEL_W'(i))));
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_cmask
    assign cmask[k] = inj_en & inj_in_check &
                      ((inj_bit_a == SEL_W'(k)) | (inj_double & (inj_bit_b == SEL_W'(k))));
  end

  assign mem_data = data ^ dmask;
  assign mem_chk  = chk_clean ^ cmask;

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder #(
  parameter int DATA_W = 256,
  parameter int ADDR_W = 32,
  parameter int HAM_W  = 9,
  parameter int CHK_W  = 10
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ce,
  output logic              out_ue,
  output logic [ADDR_W-1:0] out_err_addr
);
  import secded_pkg::*;

  localparam int LAST_POS = DATA_W + HAM_W;

  logic [HAM_W-1:0]  ham_rx;
  logic [HAM_W-1:0]  syn;
  logic              par_odd;
  logic              syn_zero;
  logic              syn_in_range;
  err_cls_e          cls;
  logic [DATA_W-1:0] flip;

  logic              valid_d, ce_d, ue_d;
  logic [DATA_W-1:0] data_d;
  logic [ADDR_W-1:0] eaddr_d;
  logic              valid_q, ce_q, ue_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] eaddr_q;

  secded_hamming #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HAM_W  (HAM_W)
  ) u_gen (
    .data (rd_data),
    .addr (rd_addr),
    .ham  (ham_rx)
  );

  assign syn          = ham_rx ^ rd_chk[HAM_W-1:0];
  assign par_odd      = (^rd_data) ^ (^rd_chk);
  assign syn_zero     = (syn == '0);
  assign syn_in_range = (syn <= HAM_W'(LAST_POS));

  always_comb begin
    if (!par_odd) cls = syn_zero ? CLS_NONE : CLS_UNCORR;
    else          cls = (syn_zero || syn_in_range) ? CLS_CORR : CLS_UNCORR;
  end

  // flip the data bit the syndrome points at (odd parity only)
  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int POS = data_pos(i);
    assign flip[i] = par_odd & (syn == HAM_W'(POS));
  end

  // next state
  always_comb begin
    valid_d = rd_valid;
    ce_d    = rd_valid & (cls == CLS_CORR);
    ue_d    = rd_valid & (cls == CLS_UNCORR);
    data_d  = rd_data ^ flip;
    eaddr_d = (cls != CLS_NONE) ? rd_addr : '0;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q <= 1'b0;
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ce_q    <= ce_d;
      ue_q    <= ue_d;
    end
  end

  // payload registers, loaded on a read only
  always_ff @(posedge clk) begin
    if (rd_valid) begin
      data_q  <= data_d;
      eaddr_q <= eaddr_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_ce       = ce_q;
  assign out_ue       = ue_q;
  assign out_data     = data_q;
  assign out_err_addr = eaddr_q;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_valid |=> !out_valid);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !(out_ce && out_ue));
  assert_flags_need_valid_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_ce || out_ue) |-> out_valid);
  assert_clean_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ce && !out_ue) |-> (out_data == $past(rd_data)));
  assert_err_addr_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_ce || out_ue) |-> (out_err_addr == $past(rd_addr)));
  assert_clean_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ce && !out_ue) |-> (out_err_addr == '0));

endmodule

// File: rtl/secded_addr_codec.sv
module secded_addr_codec #(
  parameter  int DATA_W = 256,
  parameter  int ADDR_W = 32,
  localparam int HAM_W  = secded_pkg::ham_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1,
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              inj_en,
  input  logic              inj_double,
  input  logic              inj_in_check,
  input  logic [SEL_W-1:0]  inj_bit_a,
  input  logic [SEL_W-1:0]  inj_bit_b,
  output logic [DATA_W-1:0] wr_mem_data,
  output logic [CHK_W-1:0]  wr_mem_chk,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ce,
  output logic              out_ue,
  output logic [ADDR_W-1:0] out_err_addr
);

  logic [1:0] rst_sync;
  logic       rst_sn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  secded_encoder #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HAM_W  (HAM_W),
    .CHK_W  (CHK_W),
    .SEL_W  (SEL_W)
  ) u_enc (
    .data         (wr_data),
    .addr         (wr_addr),
    .inj_en       (inj_en),
    .inj_double   (inj_double),
    .inj_in_check (inj_in_check),
    .inj_bit_a    (inj_bit_a),
    .inj_bit_b    (inj_bit_b),
    .mem_data     (wr_mem_data),
    .mem_chk      (wr_mem_chk)
  );

  secded_decoder #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HAM_W  (HAM_W),
    .CHK_W  (CHK_W)
  ) u_dec (
    .clk          (clk),
    .rst_sn       (rst_sn),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_chk       (rd_chk),
    .rd_addr      (rd_addr),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ce       (out_ce),
    .out_ue       (out_ue),
    .out_err_addr (out_err_addr)
  );

  assert_no_inject_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    !inj_en |-> (wr_mem_data == wr_data));
  assert_single_data_flip_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (inj_en && !inj_double && !inj_in_check) |-> ($countones(wr_mem_data ^ wr_data) == 1));
  assert_double_data_flip_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (inj_en && inj_double && !inj_in_check && (inj_bit_a != inj_bit_b))
      |-> ($countones(wr_mem_data ^ wr_data) == 2));
  assert_check_inject_spares_data_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (inj_en && inj_in_check) |-> (wr_mem_data == wr_data));

endmodule

// File: tb/sim_secded_addr_codec.sv
`timescale 1ns/1ps
module sim_secded_addr_codec;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] wr_data;
  logic [31:0]  wr_addr;
  logic         inj_en, inj_double, inj_in_check;
  logic [7:0]   inj_bit_a, inj_bit_b;
  logic [255:0] wr_mem_data;
  logic [9:0]   wr_mem_chk;
  logic         rd_valid;
  logic [255:0] rd_data;
  logic [9:0]   rd_chk;
  logic [31:0]  rd_addr;
  logic         out_valid;
  logic [255:0] out_data;
  logic         out_ce, out_ue;
  logic [31:0]  out_err_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [255:0] cap_d;
  logic [9:0]   cap_c;

  always #2.5 clk = ~clk;

  secded_addr_codec u0 (
    .clk (clk), .rst_n (rst_n),
    .wr_data (wr_data), .wr_addr (wr_addr),
    .inj_en (inj_en), .inj_double (inj_double), .inj_in_check (inj_in_check),
    .inj_bit_a (inj_bit_a), .inj_bit_b (inj_bit_b),
    .wr_mem_data (wr_mem_data), .wr_mem_chk (wr_mem_chk),
    .rd_valid (rd_valid), .rd_data (rd_data), .rd_chk (rd_chk), .rd_addr (rd_addr),
    .out_valid (out_valid), .out_data (out_data),
    .out_ce (out_ce), .out_ue (out_ue), .out_err_addr (out_err_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // position of data bit idx, skipping power-of-two slots
  function automatic int ref_pos(input int idx);
    int p;
    p = idx + 1;
    for (int k = 0; (1 << k) <= p; k++) p++;
    return p;
  endfunction

  function automatic logic [9:0] ref_chk(input logic [255:0] d, input logic [31:0] a);
    logic [8:0] h;
    h = '0;
    for (int i = 0; i < 256; i++) if (d[i]) h = h ^ 9'(ref_pos(i));
    for (int j = 0; j < 32; j++)  if (a[j]) h = h ^ 9'(j + 1);
    return {(^d) ^ (^h), h};
  endfunction

  task automatic do_write(input logic [255:0] d, input logic [31:0] a, input bit en,
                          input bit dbl, input bit inchk, input int ba, input int bb);
    @(negedge clk);
    wr_data = d; wr_addr = a;
    inj_en = en; inj_double = dbl; inj_in_check = inchk;
    inj_bit_a = 8'(ba); inj_bit_b = 8'(bb);
    #1;
    cap_d = wr_mem_data;
    cap_c = wr_mem_chk;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_read(input logic [255:0] d, input logic [9:0] c, input logic [31:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_chk = c; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [255:0] d, input bit ce,
                               input bit ue, input logic [31:0] ea);
    check(out_valid == 1'b1, "R2", {req, " valid"}, 256'(out_valid), 256'(1));
    check(out_data == d, req, "data", out_data, d);
    check(out_ce == ce, req, "ce", 256'(out_ce), 256'(ce));
    check(out_ue == ue, req, "ue", 256'(out_ue), 256'(ue));
    check(out_err_addr == ea, "R8", {req, " err_addr"}, 256'(out_err_addr), 256'(ea));
  endtask

  localparam logic [255:0] PAT_A = {8{32'hC3A5_0F96}} ^ (256'h1 << 201);
  localparam logic [31:0]  ADR_A = 32'h8123_4560;

  task automatic t_reset();
    check(out_valid == 1'b0, "R11", "valid after reset", 256'(out_valid), 256'(0));
    check(out_ce == 1'b0,    "R11", "ce after reset",    256'(out_ce),    256'(0));
    check(out_ue == 1'b0,    "R11", "ue after reset",    256'(out_ue),    256'(0));
  endtask

  task automatic t_encode();
    logic [255:0] pats [3];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = PAT_A;
    for (int n = 0; n < 3; n++) begin
      do_write(pats[n], ADR_A ^ 32'(n), 1'b0, 1'b0, 1'b0, 0, 0);
      check(cap_d == pats[n], "R1", "data unchanged", cap_d, pats[n]);
      check(cap_c == ref_chk(pats[n], ADR_A ^ 32'(n)), "R1", "check field",
            256'(cap_c), 256'(ref_chk(pats[n], ADR_A ^ 32'(n))));
    end
  endtask

  task automatic t_clean();
    do_write(PAT_A, ADR_A, 1'b0, 1'b0, 1'b0, 0, 0);
    do_read(cap_d, cap_c, ADR_A);
    expect_result("R3", PAT_A, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "valid drops", 256'(out_valid), 256'(0));
  endtask

  task automatic t_single_data();
    int idx [4] = '{0, 1, 127, 255};
    for (int n = 0; n < 4; n++) begin
      do_write(PAT_A, ADR_A, 1'b1, 1'b0, 1'b0, idx[n], 0);
      check(cap_d == (PAT_A ^ (256'h1 << idx[n])), "R9", "single data flip",
            cap_d, PAT_A ^ (256'h1 << idx[n]));
      do_read(cap_d, cap_c, ADR_A);
      expect_result("R4", PAT_A, 1'b1, 1'b0, ADR_A);
    end
  endtask

  task automatic t_single_check();
    logic [9:0] ref_c;
    ref_c = ref_chk(PAT_A, ADR_A);
    for (int k = 0; k < 10; k++) begin
      do_write(PAT_A, ADR_A, 1'b1, 1'b0, 1'b1, k, 0);
      check(cap_c == (ref_c ^ (10'h1 << k)), "R9", "single check flip",
            256'(cap_c), 256'(ref_c ^ (10'h1 << k)));
      do_read(cap_d, cap_c, ADR_A);
      expect_result("R5", PAT_A, 1'b1, 1'b0, ADR_A);
    end
    // index beyond the check field flips nothing
    do_write(PAT_A, ADR_A, 1'b1, 1'b0, 1'b1, 12, 0);
    check(cap_c == ref_c, "R9", "out-of-range check index", 256'(cap_c), 256'(ref_c));
    do_read(cap_d, cap_c, ADR_A);
    expect_result("R9", PAT_A, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_double();
    logic [9:0] ref_c;
    ref_c = ref_chk(PAT_A, ADR_A);
    do_write(PAT_A, ADR_A, 1'b1, 1'b1, 1'b0, 5, 250);
    check(cap_d == (PAT_A ^ (256'h1 << 5) ^ (256'h1 << 250)), "R10", "double data flip",
          cap_d, PAT_A ^ (256'h1 << 5) ^ (256'h1 << 250));
    do_read(cap_d, cap_c, ADR_A);
    check(out_ue == 1'b1, "R6", "ue data pair", 256'(out_ue), 256'(1));
    check(out_ce == 1'b0, "R6", "ce data pair", 256'(out_ce), 256'(0));
    check(out_err_addr == ADR_A, "R8", "addr data pair", 256'(out_err_addr), 256'(ADR_A));

    do_write(PAT_A, ADR_A, 1'b1, 1'b1, 1'b1, 0, 9);
    check(cap_c == (ref_c ^ 10'h201), "R10", "double check flip",
          256'(cap_c), 256'(ref_c ^ 10'h201));
    do_read(cap_d, cap_c, ADR_A);
    check(out_ue == 1'b1, "R6", "ue check pair", 256'(out_ue), 256'(1));
    check(out_ce == 1'b0, "R6", "ce check pair", 256'(out_ce), 256'(0));

    do_write(PAT_A, ADR_A, 1'b0, 1'b0, 1'b0, 0, 0);
    do_read(cap_d ^ (256'h1 << 40), cap_c ^ 10'h008, ADR_A);
    check(out_ue == 1'b1, "R6", "ue mixed pair", 256'(out_ue), 256'(1));
    check(out_ce == 1'b0, "R6", "ce mixed pair", 256'(out_ce), 256'(0));
  endtask

  task automatic t_addr();
    logic [31:0] bad [3];
    bad[0] = ADR_A ^ 32'h0000_0001;
    bad[1] = ADR_A ^ 32'h8000_0000;
    bad[2] = ADR_A ^ 32'h0000_0300;
    do_write(PAT_A, ADR_A, 1'b0, 1'b0, 1'b0, 0, 0);
    for (int n = 0; n < 3; n++) begin
      do_read(cap_d, cap_c, bad[n]);
      check(out_valid == 1'b1, "R2", "valid on addr fault", 256'(out_valid), 256'(1));
      check(out_ue == 1'b1, "R7", "ue on addr fault", 256'(out_ue), 256'(1));
      check(out_ce == 1'b0, "R7", "ce on addr fault", 256'(out_ce), 256'(0));
      check(out_err_addr == bad[n], "R8", "addr fault report",
            256'(out_err_addr), 256'(bad[n]));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    wr_data = '0; wr_addr = '0;
    inj_en = 1'b0; inj_double = 1'b0; inj_in_check = 1'b0;
    inj_bit_a = '0; inj_bit_b = '0;
    rd_valid = 1'b0; rd_data = '0; rd_chk = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_encode();
    t_clean();
    t_single_data();
    t_single_check();
    t_double();
    t_addr();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule